// File: doc/BRIEF.md
# Banked Memory Management Unit

This unit sits between a CPU with a 16-bit logical address and a memory system with a 22-bit physical address. The logical space is cut into four 16 KB windows. The top two logical address bits choose one of four 8-bit page entries. That entry becomes physical address bits 21 down to 14, and logical bits 13 down to 0 pass straight through. Software loads the entries through a small write port and can read any entry back. It then sets a global enable.

Out of reset the enable is clear. While it is clear, every window shows the highest 16 KB physical page, which lets a boot ROM placed there run from any logical address. Boot code loads the page entries first and sets the enable after that.

The physical address is also decoded into chip selects. Physical bits 20:19 pick one of four sockets on a memory card, and each socket covers 512 KB. Physical bit 21 picks one of two cards, but only when a second card is fitted. With a single card, that card always decodes.

Top module: `page_mapper`

## Requirements
- R1: A clock edge with `rst_n` low clears `map_enabled`, and it stays 0 until a later enable write sets it.
- R2: While `map_enabled` is 0, `phys_addr[21:14]` is all ones for every `cpu_addr`, even after entry writes, and `phys_addr[13:0]` equals `cpu_addr[13:0]`.
- R3: While `map_enabled` is 1, `phys_addr[21:14]` equals the entry selected by `cpu_addr[15:14]` (0 to 3), and `phys_addr[13:0]` equals `cpu_addr[13:0]`.
- R4: With `ent_we` high at a clock edge, entry `ent_idx` takes `ent_wdata`. Accesses from the next cycle on use the new value, and the other three entries keep their values.
- R5: `rd_data` combinationally shows the entry selected by `rd_idx`.
- R6: With `en_we` high at a clock edge, `map_enabled` takes `en_val`. Toggling the enable leaves all entries unchanged.
- R7: `sock_sel` is one-hot, with bit n set where n = `phys_addr[20:19]`.
- R8: With `dual_card` = 1, `card_sel` is 2'b01 when `phys_addr[21]` is 0 and 2'b10 when it is 1.
- R9: With `dual_card` = 0, `card_sel` is 2'b01 for every physical address.
- R10: An entry write and an enable write in the same cycle both take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the enable |
| cpu_addr | input | 16 | CPU logical address |
| ent_we | input | 1 | Page entry write strobe |
| ent_idx | input | 2 | Index of the entry to write |
| ent_wdata | input | 8 | Physical page number to store |
| en_we | input | 1 | Enable write strobe |
| en_val | input | 1 | New value of the enable |
| rd_idx | input | 2 | Index of the entry to read back |
| dual_card | input | 1 | High when a second memory card is fitted |
| rd_data | output | 8 | Read-back entry value |
| map_enabled | output | 1 | Current enable state |
| phys_addr | output | 22 | Physical address |
| sock_sel | output | 4 | One-hot socket select |
| card_sel | output | 2 | One-hot card select |

## Verification
Translation, read-back and both select decodes are combinational from `cpu_addr`, `rd_idx` and the stored state. The bench drives those inputs and samples 1 ns later, inside the same cycle. Entry writes and enable writes are registered, so they are due one clock edge after the strobe. The bench raises a strobe, waits for one rising edge, lowers it 1 ns after that edge and only then samples. Reset is checked the same way, on the first sample after the edge where `rst_n` was low.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int unsigned LOG_AW_DEF  = 16;
  localparam int unsigned PHYS_AW_DEF = 22;
  localparam int unsigned PAGE_W_DEF  = 14;
  localparam int unsigned SOCK_W_DEF  = 2;

  // one-hot decode of a small field, width fixed by caller through slicing
  function automatic logic [15:0] onehot16(input logic [3:0] v);
    return 16'(1) << v;
  endfunction
endpackage

// File: rtl/page_regfile.sv
module page_regfile #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned ENT_W = 8,
  localparam int unsigned NUM_WIN = 1 << IDX_W
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         widx,
  input  logic [ENT_W-1:0]         wdata,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [ENT_W-1:0]         rd_data,
  input  logic [IDX_W-1:0]         win_idx,
  output logic [ENT_W-1:0]         win_data,
  output logic [NUM_WIN*ENT_W-1:0] ent_flat
);
  logic [ENT_W-1:0] ent_q [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(g))) ent_q[g] <= wdata;
    end
    assign ent_flat[g*ENT_W +: ENT_W] = ent_q[g];
  end

  assign rd_data  = ent_q[rd_idx];
  assign win_data = ent_q[win_idx];
endmodule

// File: rtl/map_ctrl.sv
module map_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_val,
  output logic enabled
);
  always_ff @(posedge clk) begin
    if (!rst_n)     enabled <= 1'b0;
    else if (en_we) enabled <= en_val;
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int unsigned LOG_AW = 16,
  parameter int unsigned PAGE_W = 14,
  parameter int unsigned ENT_W  = 8,
  localparam int unsigned IDX_W   = LOG_AW - PAGE_W,
  localparam int unsigned PHYS_AW = ENT_W + PAGE_W
) (
  input  logic               enabled,
  input  logic [LOG_AW-1:0]  cpu_addr,
  input  logic [ENT_W-1:0]   win_data,
  output logic [IDX_W-1:0]   win_idx,
  output logic [PHYS_AW-1:0] phys
);
  // mapped page when enabled, otherwise the topmost page
  function automatic logic [PHYS_AW-1:0] xlate(input logic en,
                                               input logic [ENT_W-1:0] bank,
                                               input logic [PAGE_W-1:0] off);
    logic [ENT_W-1:0] pg;
    pg = en ? bank : {ENT_W{1'b1}};
    return {pg, off};
  endfunction

  assign win_idx = cpu_addr[LOG_AW-1:PAGE_W];
  assign phys    = xlate(enabled, win_data, cpu_addr[PAGE_W-1:0]);
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int unsigned SOCK_W = 2,
  localparam int unsigned NUM_SOCK = 1 << SOCK_W
) (
  input  logic [SOCK_W:0]     hi_bits,   // {card bit, socket field}
  input  logic                dual_card,
  output logic [NUM_SOCK-1:0] sock_sel,
  output logic [1:0]          card_sel
);
  logic card_bit;
  assign card_bit = hi_bits[SOCK_W];

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    assign sock_sel[g] = (hi_bits[SOCK_W-1:0] == SOCK_W'(g));
  end

  assign card_sel[0] = !dual_card || !card_bit;
  assign card_sel[1] = dual_card && card_bit;
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mmu_pkg::*;
#(
  parameter int unsigned LOG_AW  = LOG_AW_DEF,
  parameter int unsigned PHYS_AW = PHYS_AW_DEF,
  parameter int unsigned PAGE_W  = PAGE_W_DEF,
  parameter int unsigned SOCK_W  = SOCK_W_DEF,
  localparam int unsigned IDX_W    = LOG_AW - PAGE_W,
  localparam int unsigned ENT_W    = PHYS_AW - PAGE_W,
  localparam int unsigned NUM_WIN  = 1 << IDX_W,
  localparam int unsigned NUM_SOCK = 1 << SOCK_W,
  localparam int unsigned SOCK_LSB = PHYS_AW - 1 - SOCK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LOG_AW-1:0]   cpu_addr,
  input  logic                ent_we,
  input  logic [IDX_W-1:0]    ent_idx,
  input  logic [ENT_W-1:0]    ent_wdata,
  input  logic                en_we,
  input  logic                en_val,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                dual_card,
  output logic [ENT_W-1:0]    rd_data,
  output logic                map_enabled,
  output logic [PHYS_AW-1:0]  phys_addr,
  output logic [NUM_SOCK-1:0] sock_sel,
  output logic [1:0]          card_sel
);
  logic [IDX_W-1:0]         win_idx;
  logic [ENT_W-1:0]         win_data;
  logic [NUM_WIN*ENT_W-1:0] ent_flat;

  page_regfile #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_regs (
    .clk(clk), .we(ent_we), .widx(ent_idx), .wdata(ent_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .win_idx(win_idx), .win_data(win_data), .ent_flat(ent_flat)
  );

  map_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_val(en_val),
    .enabled(map_enabled)
  );

  addr_xlate #(.LOG_AW(LOG_AW), .PAGE_W(PAGE_W), .ENT_W(ENT_W)) u_xlate (
    .enabled(map_enabled), .cpu_addr(cpu_addr), .win_data(win_data),
    .win_idx(win_idx), .phys(phys_addr)
  );

  sel_decode #(.SOCK_W(SOCK_W)) u_sel (
    .hi_bits(phys_addr[PHYS_AW-1:SOCK_LSB]), .dual_card(dual_card),
    .sock_sel(sock_sel), .card_sel(card_sel)
  );
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
  parameter int unsigned LOG_AW  = 16,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned PAGE_W  = 14,
  parameter int unsigned SOCK_W  = 2,
  localparam int unsigned IDX_W    = LOG_AW - PAGE_W,
  localparam int unsigned ENT_W    = PHYS_AW - PAGE_W,
  localparam int unsigned NUM_WIN  = 1 << IDX_W,
  localparam int unsigned NUM_SOCK = 1 << SOCK_W,
  localparam int unsigned SOCK_LSB = PHYS_AW - 1 - SOCK_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LOG_AW-1:0]        cpu_addr,
  input logic                     ent_we,
  input logic [IDX_W-1:0]         ent_idx,
  input logic [ENT_W-1:0]         ent_wdata,
  input logic                     en_we,
  input logic                     en_val,
  input logic                     dual_card,
  input logic                     map_enabled,
  input logic [PHYS_AW-1:0]       phys_addr,
  input logic [NUM_SOCK-1:0]      sock_sel,
  input logic [1:0]               card_sel,
  input logic [NUM_WIN*ENT_W-1:0] ent_flat
);
  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
    if (rst_seen_q) begin
      a_reset_off_r1: assert (!map_enabled);
    end
  end

  p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !map_enabled |-> phys_addr[PHYS_AW-1:PAGE_W] == {ENT_W{1'b1}});

  p_xlate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_enabled |->
      phys_addr[PHYS_AW-1:PAGE_W] == ent_flat[cpu_addr[LOG_AW-1:PAGE_W]*ENT_W +: ENT_W]);

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PAGE_W-1:0] == cpu_addr[PAGE_W-1:0]);

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |=> ent_flat[$past(ent_idx)*ENT_W +: ENT_W] == $past(ent_wdata));

  p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> map_enabled == $past(en_val));

  p_sock_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sock_sel) == 1 && sock_sel[phys_addr[SOCK_LSB +: SOCK_W]]);

  p_card_dual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dual_card |-> $countones(card_sel) == 1 && card_sel[phys_addr[PHYS_AW-1]]);

  p_card_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_card |-> card_sel == 2'b01);
endmodule

bind page_mapper page_mapper_chk #(
  .LOG_AW(LOG_AW), .PHYS_AW(PHYS_AW), .PAGE_W(PAGE_W), .SOCK_W(SOCK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ent_we(ent_we),
  .ent_idx(ent_idx), .ent_wdata(ent_wdata), .en_we(en_we), .en_val(en_val),
  .dual_card(dual_card), .map_enabled(map_enabled), .phys_addr(phys_addr),
  .sock_sel(sock_sel), .card_sel(card_sel), .ent_flat(ent_flat)
);

// File: tb/page_mapper_tb.sv
`timescale 1ns/1ps
module page_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        ent_we = 1'b0;
  logic [1:0]  ent_idx = '0;
  logic [7:0]  ent_wdata = '0;
  logic        en_we = 1'b0;
  logic        en_val = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic        dual_card = 1'b0;
  logic [7:0]  rd_data;
  logic        map_enabled;
  logic [21:0] phys_addr;
  logic [3:0]  sock_sel;
  logic [1:0]  card_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int m [4];
  bit m_en = 0;

  always #5 clk = ~clk;

  page_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ent_we(ent_we),
    .ent_idx(ent_idx), .ent_wdata(ent_wdata), .en_we(en_we), .en_val(en_val),
    .rd_idx(rd_idx), .dual_card(dual_card), .rd_data(rd_data),
    .map_enabled(map_enabled), .phys_addr(phys_addr), .sock_sel(sock_sel),
    .card_sel(card_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_phys(input bit en, input int bank, input int a);
    int pg;
    pg = en ? bank : 255;
    return pg * 16384 + (a % 16384);
  endfunction

  function automatic int exp_sock(input int p);
    return 1 << ((p / 524288) % 4);
  endfunction

  function automatic int exp_card(input bit dual, input int p);
    return dual ? (1 << (p / 2097152)) : 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_entry(input int idx, input int v);
    ent_we = 1'b1; ent_idx = 2'(idx); ent_wdata = 8'(v);
    tick();
    ent_we = 1'b0;
    m[idx] = v;
  endtask

  task automatic wr_enable(input bit v);
    en_we = 1'b1; en_val = v;
    tick();
    en_we = 1'b0;
    m_en = v;
  endtask

  task automatic probe(input int a, input bit dual);
    int p;
    cpu_addr = 16'(a); dual_card = dual;
    #1;
    p = exp_phys(m_en, m[a / 16384], a);
    check(m_en ? "R3 translate" : "R2 mirror", int'(phys_addr), p);
    check("R7 socket", int'(sock_sel), exp_sock(p));
    check(dual ? "R8 card dual" : "R9 card single", int'(card_sel), exp_card(dual, p));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    tick(); tick();
    rst_n = 1'b1;
    check("R1 off after reset", int'(map_enabled), 0);

    // disabled: mirror of top page for a spread of addresses
    for (int i = 0; i < 64; i++) probe((i * 1031 + 7) % 65536, i[0]);

    // entry writes while disabled have no effect on translation
    wr_entry(0, 8'h12); wr_entry(1, 8'h5a); wr_entry(2, 8'h80); wr_entry(3, 8'hc3);
    check("R1 still off", int'(map_enabled), 0);
    for (int w = 0; w < 4; w++) begin
      probe(w * 16384 + 100, 1'b1);
      rd_idx = 2'(w); #1;
      check("R5 readback", int'(rd_data), m[w]);
    end

    wr_enable(1'b1);
    check("R6 enable set", int'(map_enabled), 1);
    for (int w = 0; w < 4; w++) probe(w * 16384 + 16383, 1'b1);

    // exhaustive sweep: every value into every entry
    for (int idx = 0; idx < 4; idx++) begin
      for (int v = 0; v < 256; v++) begin
        wr_entry(idx, v);
        rd_idx = 2'(idx); #1;
        check("R4 R5 written value", int'(rd_data), v);
        for (int w = 0; w < 4; w++) probe(w * 16384 + ((v * 37 + w * 11) % 16384), v[0]);
      end
    end
    for (int w = 0; w < 4; w++) begin
      rd_idx = 2'(w); #1;
      check("R4 others kept", int'(rd_data), 255);
    end

    // distinct entries, check neighbours untouched
    wr_entry(0, 8'h01); wr_entry(1, 8'h22); wr_entry(2, 8'h64); wr_entry(3, 8'ha7);
    wr_entry(2, 8'hf0);
    for (int w = 0; w < 4; w++) begin
      rd_idx = 2'(w); #1;
      check("R4 neighbour", int'(rd_data), m[w]);
      probe(w * 16384 + 4321, 1'b0);
    end

    // simultaneous entry write and disable
    ent_we = 1'b1; ent_idx = 2'd1; ent_wdata = 8'h3c; en_we = 1'b1; en_val = 1'b0;
    tick();
    ent_we = 1'b0; en_we = 1'b0; m[1] = 8'h3c; m_en = 0;
    check("R10 enable cleared", int'(map_enabled), 0);
    rd_idx = 2'd1; #1;
    check("R10 entry written", int'(rd_data), 8'h3c);
    probe(16384 + 5, 1'b1);

    // re-enable: entries retained across toggling
    wr_enable(1'b1);
    for (int w = 0; w < 4; w++) begin
      rd_idx = 2'(w); #1;
      check("R6 entries kept", int'(rd_data), m[w]);
      probe(w * 16384 + 9, 1'b1);
    end

    // reset mid-run returns to mirrored mode
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    m_en = 0;
    check("R1 reset clears", int'(map_enabled), 0);
    probe(32768 + 77, 1'b1);
    tick();
    check("R1 stays off", int'(map_enabled), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule